// File: doc/BRIEF.md
# Software-Loaded Set-Associative Translation Buffer

This block is a four-way, thirty-two-set address translation buffer. Software fills it; the block never refills itself. A lookup takes a 32-bit virtual address. One cycle later it reports one of three outcomes. A hit returns the translated physical address and the stored attribute flags. An invalid-hit means the tag matched but the entry's valid bit was clear. A miss means no way matched. Hit and invalid-hit also report the matching way.

Software writes an entry in three steps. It first writes two staging words: a high word that holds the virtual page number, and a low word that holds the physical page number, a two-bit protection key and the flag bits. It then issues a single load command. The load copies both staging words into the set selected by the virtual page number, in the way named by a replacement field. Software may overwrite that field. An invalid-hit points the field at the faulting way, so a load issued without changing the field refills the stale entry. After each load the field steps round-robin.

Top module: `sw_tlb`

## Requirements
- R1: After reset, no result is flagged valid and the replacement field is 0. Every entry is invalid with an all-zero tag, so a lookup of an address whose bits 31:10 are zero reports invalid-hit in way 0.
- R2: A lookup presented on `lookup_i` produces its result with `res_valid_o` high in the next cycle. In that cycle exactly one of `hit_o`, `inv_hit_o`, `miss_o` is set. When no lookup was presented, `res_valid_o` is low.
- R3: The set index is VA[16:12]. The low-word bit `lo_i[24]` is the page-size bit (1 = 4 KB, 0 = 1 KB). A 4 KB entry compares its stored VPN bits 21:2 with VA[31:12]. A 1 KB entry compares all 22 stored VPN bits with VA[31:10].
- R4: A tag match on an entry whose valid bit (`lo_i[28]`) is 0 reports invalid-hit with that way number. A tag match on an entry whose valid bit is 1 reports hit. No tag match reports miss.
- R5: If several ways match, the lowest-numbered way wins.
- R6: On a hit the physical address is {PPN[21:2], VA[11:0]} for a 4 KB page and {PPN, VA[9:0]} for a 1 KB page. PPN is `lo_i[21:0]`.
- R7: On a hit the block returns the stored key (`lo_i[23:22]`), cacheable (`lo_i[25]`), dirty (`lo_i[26]`) and share (`lo_i[27]`) bits.
- R8: A load writes the staged high word (VPN = VA[31:10]) and the staged low word into set VPN[6:2], in the way equal to the replacement field at that cycle.
- R9: A lookup presented in the cycle right after a load sees the newly written entry.
- R10: A replacement-field write takes effect in the next cycle and takes priority over every other update of the field. A load in the same cycle uses the old value.
- R11: A lookup that reports invalid-hit sets the replacement field to the faulting way.
- R12: Each load without a concurrent field write or invalid-hit advances the field by one, wrapping from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hi_we_i | input | 1 | Write high staging word |
| hi_i | input | 22 | Virtual page number VA[31:10] |
| lo_we_i | input | 1 | Write low staging word |
| lo_i | input | 29 | PPN[21:0], key[23:22], size[24], cacheable[25], dirty[26], share[27], valid[28] |
| load_i | input | 1 | Copy staging words into the buffer |
| repl_we_i | input | 1 | Overwrite replacement field |
| repl_i | input | 2 | New replacement field value |
| repl_o | output | 2 | Current replacement field |
| lookup_i | input | 1 | Start a lookup |
| va_i | input | 32 | Virtual address to look up |
| res_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Valid entry matched |
| inv_hit_o | output | 1 | Tag matched an invalid entry |
| miss_o | output | 1 | No tag matched |
| way_o | output | 2 | Matching way |
| pa_o | output | 32 | Translated physical address |
| key_o | output | 2 | Stored protection key |
| big_o | output | 1 | Stored page-size bit |
| cache_o | output | 1 | Stored cacheable bit |
| dirty_o | output | 1 | Stored dirty bit |
| share_o | output | 1 | Stored share bit |

## Verification
A corrupted entry or a wrong set index shows up in the very next result cycle of any lookup to that page. The result changes class between hit, invalid-hit and miss, or a wrong way or physical address is reported. A replacement field that drifts is visible at once on `repl_o`. It also shows one lookup later, because a refill lands in the wrong way and the lookup either still reports invalid-hit or reports an unexpected way. Bad page-size handling only shows on addresses that differ in VA[11:10], so the vectors place 1 KB neighbours side by side.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
  localparam int VA_W  = 32;
  localparam int VPN_W = 22;
  localparam int PPN_W = 22;
  localparam int KEY_W = 2;
  localparam int LO_W  = PPN_W + KEY_W + 5;

  // low word layout is {valid, share, dirty, cache, big, key, ppn}
  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic             valid;
    logic             share;
    logic             dirty;
    logic             cache;
    logic             big;
    logic [KEY_W-1:0] key;
    logic [PPN_W-1:0] ppn;
  } entry_t;
endpackage

// File: rtl/sw_tlb_store.sv
module sw_tlb_store
  import sw_tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 32,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WAY_W-1:0] wway_i,
  input  logic [IDX_W-1:0] wset_i,
  input  entry_t           wdata_i,
  input  logic [IDX_W-1:0] rset_i,
  output entry_t           rd_o [WAYS]
);
  entry_t mem_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem_q[s][w] <= '0;
    end else if (we_i) begin
      mem_q[wset_i][wway_i] <= wdata_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_o[w] = mem_q[rset_i][w];
  end

  // R8
  load_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wset_i)][$past(wway_i)] == $past(wdata_i));
endmodule

// File: rtl/sw_tlb_match.sv
module sw_tlb_match
  import sw_tlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [VA_W-1:0]  va_i,
  input  entry_t           ent_i [WAYS],
  output logic             any_o,
  output logic [WAY_W-1:0] way_o,
  output entry_t           ent_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    // 4 KB pages ignore VPN bits 1:0 (VA[11:10])
    assign eq[w] = ent_i[w].big ? (ent_i[w].vpn[VPN_W-1:2] == va_i[VA_W-1:12])
                                : (ent_i[w].vpn == va_i[VA_W-1:10]);
  end

  always_comb begin
    any_o = 1'b0;
    way_o = '0;
    ent_o = ent_i[0];
    for (int w = WAYS-1; w >= 0; w--) begin
      if (eq[w]) begin
        any_o = 1'b1;
        way_o = WAY_W'(w);
        ent_o = ent_i[w];
      end
    end
  end

  // R5
  lowest_way_chk: assert final (!any_o || eq[way_o]);
endmodule

// File: rtl/sw_tlb_repl.sv
module sw_tlb_repl #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WAY_W-1:0] wdata_i,
  input  logic             inv_i,
  input  logic [WAY_W-1:0] inv_way_i,
  input  logic             load_i,
  output logic [WAY_W-1:0] repl_o
);
  logic [WAY_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (we_i)   q <= wdata_i;
    else if (inv_i)  q <= inv_way_i;
    else if (load_i) q <= (q == WAY_W'(WAYS-1)) ? '0 : q + 1'b1;
  end

  assign repl_o = q;

  // R10
  sw_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> repl_o == $past(wdata_i));
  // R11
  inv_retarget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && !we_i) |=> repl_o == $past(inv_way_i));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !inv_i && !load_i) |=> $stable(repl_o));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import sw_tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 32,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_we_i,
  input  logic [VPN_W-1:0] hi_i,
  input  logic             lo_we_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic             load_i,
  input  logic             repl_we_i,
  input  logic [WAY_W-1:0] repl_i,
  output logic [WAY_W-1:0] repl_o,
  input  logic             lookup_i,
  input  logic [VA_W-1:0]  va_i,
  output logic             res_valid_o,
  output logic             hit_o,
  output logic             inv_hit_o,
  output logic             miss_o,
  output logic [WAY_W-1:0] way_o,
  output logic [VA_W-1:0]  pa_o,
  output logic [KEY_W-1:0] key_o,
  output logic             big_o,
  output logic             cache_o,
  output logic             dirty_o,
  output logic             share_o
);
  logic [VPN_W-1:0] hi_q;
  logic [LO_W-1:0]  lo_q;
  entry_t           rd [WAYS];
  entry_t           m_ent;
  logic             m_any;
  logic [WAY_W-1:0] m_way;
  logic             inv_now;
  logic [VA_W-1:0]  pa_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_we_i) hi_q <= hi_i;
      if (lo_we_i) lo_q <= lo_i;
    end
  end

  sw_tlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (load_i),
    .wway_i  (repl_o),
    .wset_i  (hi_q[IDX_W+1:2]),
    .wdata_i ({hi_q, lo_q}),
    .rset_i  (va_i[12+IDX_W-1:12]),
    .rd_o    (rd)
  );

  sw_tlb_match #(.WAYS(WAYS)) u_match (
    .va_i  (va_i),
    .ent_i (rd),
    .any_o (m_any),
    .way_o (m_way),
    .ent_o (m_ent)
  );

  assign inv_now = lookup_i && m_any && !m_ent.valid;

  sw_tlb_repl #(.WAYS(WAYS)) u_repl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (repl_we_i),
    .wdata_i   (repl_i),
    .inv_i     (inv_now),
    .inv_way_i (m_way),
    .load_i    (load_i),
    .repl_o    (repl_o)
  );

  assign pa_d = m_ent.big ? {m_ent.ppn[PPN_W-1:2], va_i[11:0]}
                          : {m_ent.ppn, va_i[9:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      inv_hit_o   <= 1'b0;
      miss_o      <= 1'b0;
      way_o       <= '0;
      pa_o        <= '0;
      key_o       <= '0;
      big_o       <= 1'b0;
      cache_o     <= 1'b0;
      dirty_o     <= 1'b0;
      share_o     <= 1'b0;
    end else begin
      res_valid_o <= lookup_i;
      if (lookup_i) begin
        hit_o     <= m_any && m_ent.valid;
        inv_hit_o <= m_any && !m_ent.valid;
        miss_o    <= !m_any;
        way_o     <= m_way;
        pa_o      <= pa_d;
        key_o     <= m_ent.key;
        big_o     <= m_ent.big;
        cache_o   <= m_ent.cache;
        dirty_o   <= m_ent.dirty;
        share_o   <= m_ent.share;
      end
    end
  end

  // R2
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $countones({hit_o, inv_hit_o, miss_o}) == 1);
  // R2
  result_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> res_valid_o);
  // R2
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> !res_valid_o);
  // R11
  inv_points_repl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && !repl_we_i) |=> (inv_hit_o -> repl_o == way_o));
endmodule

// File: tb/sw_tlb_tb.sv
module sw_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_we = 0, lo_we = 0, load = 0, repl_we = 0, lookup = 0;
  logic [21:0] hi = '0;
  logic [28:0] lo = '0;
  logic [1:0]  repl_w = '0;
  logic [31:0] va = '0;
  logic [1:0]  repl_o, way_o, key_o;
  logic        res_valid, hit, inv, miss, big_o, cache_o, dirty_o, share_o;
  logic [31:0] pa_o;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  sw_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hi_we_i(hi_we), .hi_i(hi), .lo_we_i(lo_we), .lo_i(lo),
    .load_i(load), .repl_we_i(repl_we), .repl_i(repl_w), .repl_o(repl_o),
    .lookup_i(lookup), .va_i(va), .res_valid_o(res_valid), .hit_o(hit), .inv_hit_o(inv),
    .miss_o(miss), .way_o(way_o), .pa_o(pa_o), .key_o(key_o), .big_o(big_o),
    .cache_o(cache_o), .dirty_o(dirty_o), .share_o(share_o)
  );

  typedef struct packed {
    logic [31:0] va_ld;
    logic [21:0] ppn;
    logic [1:0]  key;
    logic        big;
    logic        v;
    logic [1:0]  way;
    logic [31:0] va_lk;
    logic [1:0]  kind;  // 0 miss, 1 hit, 2 invalid-hit
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{32'h1234_5000, 22'h21D950, 2'd2, 1'b1, 1'b1, 2'd1, 32'h1234_5ABC, 2'd1},
    '{32'h0ABC_D400, 22'h000123, 2'd1, 1'b0, 1'b1, 2'd2, 32'h0ABC_D7FF, 2'd1},
    '{32'h0ABC_D400, 22'h0003FF, 2'd3, 1'b0, 1'b1, 2'd3, 32'h0ABC_D800, 2'd0},
    '{32'h5555_6000, 22'h111110, 2'd0, 1'b1, 1'b0, 2'd0, 32'h5555_6123, 2'd2},
    '{32'h0000_7000, 22'h3FFFFC, 2'd3, 1'b1, 1'b1, 2'd3, 32'h0000_7FFC, 2'd1},
    '{32'h6000_2000, 22'h000040, 2'd1, 1'b1, 1'b1, 2'd0, 32'h7777_2000, 2'd0}
  };

  function automatic logic [28:0] mk_lo(logic [21:0] ppn, logic [1:0] key, logic big, logic v);
    // valid[28] share[27] dirty[26] cache[25] big[24] key[23:22] ppn[21:0]
    return {v, big, key[0], 1'b1, big, key, ppn};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic stage(input logic [31:0] vaddr, input logic [28:0] low);
    @(negedge clk);
    hi_we = 1; hi = vaddr[31:10]; lo_we = 1; lo = low;
    @(negedge clk);
    hi_we = 0; lo_we = 0;
  endtask

  task automatic set_repl(input logic [1:0] r);
    @(negedge clk);
    repl_we = 1; repl_w = r;
    @(negedge clk);
    repl_we = 0;
  endtask

  task automatic do_load();
    @(negedge clk);
    load = 1;
    @(negedge clk);
    load = 0;
  endtask

  task automatic do_lookup(input logic [31:0] a);
    @(negedge clk);
    lookup = 1; va = a;
    @(negedge clk);
    lookup = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(res_valid == 0, "R1", "res_valid after reset", res_valid, 0);
    chk(repl_o == 0, "R1", "repl after reset", repl_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0, "R2", "no lookup, no result", res_valid, 0);

    // table: R3 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp_pa;
      set_repl(VEC[i].way);
      stage(VEC[i].va_ld, mk_lo(VEC[i].ppn, VEC[i].key, VEC[i].big, VEC[i].v));
      do_load();
      do_lookup(VEC[i].va_lk);
      chk(res_valid, "R2", "res_valid", res_valid, 1);
      chk({miss, hit, inv} == (VEC[i].kind == 0 ? 3'b100 : VEC[i].kind == 1 ? 3'b010 : 3'b001),
          "R4", $sformatf("vec %0d outcome", i), {miss, hit, inv}, VEC[i].kind);
      if (VEC[i].kind != 0)
        chk(way_o == VEC[i].way, "R8", $sformatf("vec %0d way", i), way_o, VEC[i].way);
      if (VEC[i].kind == 1) begin
        exp_pa = VEC[i].big ? {VEC[i].ppn[21:2], VEC[i].va_lk[11:0]} : {VEC[i].ppn, VEC[i].va_lk[9:0]};
        chk(pa_o == exp_pa, "R6", $sformatf("vec %0d pa", i), pa_o, exp_pa);
        chk({key_o, big_o, cache_o, dirty_o, share_o} ==
            {VEC[i].key, VEC[i].big, 1'b1, VEC[i].key[0], VEC[i].big},
            "R7", $sformatf("vec %0d flags", i), {key_o, big_o, cache_o, dirty_o, share_o},
            {VEC[i].key, VEC[i].big, 1'b1, VEC[i].key[0], VEC[i].big});
      end
    end

    // R11: invalid-hit retargets field to faulting way 0
    set_repl(2'd3);
    do_lookup(32'h5555_6000);
    chk(inv && way_o == 0, "R11", "inv-hit way", {inv, way_o}, {1'b1, 2'd0});
    chk(repl_o == 0, "R11", "repl after inv-hit", repl_o, 0);
    stage(32'h5555_6000, mk_lo(22'h0000AA, 2'd1, 1'b1, 1'b1));
    do_load();
    chk(repl_o == 1, "R12", "repl after refill", repl_o, 1);
    do_lookup(32'h5555_6010);
    chk(hit && way_o == 0, "R11", "refilled same way", {hit, way_o}, {1'b1, 2'd0});

    // R12 round-robin with wrap
    stage(32'h3333_3000, mk_lo(22'h000100, 2'd0, 1'b1, 1'b1));
    do_load();
    chk(repl_o == 2, "R12", "step 1->2", repl_o, 2);
    do_load();
    do_load();
    chk(repl_o == 0, "R12", "wrap 3->0", repl_o, 0);

    // R9 lookup right after load
    stage(32'h4444_9000, mk_lo(22'h000200, 2'd2, 1'b1, 1'b1));
    @(negedge clk);
    load = 1;
    @(negedge clk);
    load = 0; lookup = 1; va = 32'h4444_9004;
    @(negedge clk);
    lookup = 0;
    chk(hit && way_o == 0, "R9", "back-to-back hit", {hit, way_o}, {1'b1, 2'd0});
    chk(pa_o == 32'h0008_0004, "R9", "back-to-back pa", pa_o, 32'h0008_0004);

    // R10 field write concurrent with load: load uses old value 1, write wins
    stage(32'h4AAA_A000, mk_lo(22'h000300, 2'd3, 1'b1, 1'b1));
    @(negedge clk);
    load = 1; repl_we = 1; repl_w = 2'd3;
    @(negedge clk);
    load = 0; repl_we = 0;
    chk(repl_o == 3, "R10", "write beats advance", repl_o, 3);
    do_lookup(32'h4AAA_A000);
    chk(hit && way_o == 1, "R10", "load used old field", {hit, way_o}, {1'b1, 2'd1});

    // R1 + R5: untouched set, all ways tag zero invalid -> lowest way 0
    do_lookup(32'h0000_0123);
    chk(inv && way_o == 0, "R5", "reset entries lowest way", {inv, way_o}, {1'b1, 2'd0});
    chk(repl_o == 0, "R1", "repl after zero-tag inv-hit", repl_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule